// File: doc/BRIEF.md
# Core Tick Timer

A free-running tick timer for a processor core. Software reaches it through the special-purpose register port: one word-wide write/read address selects the timer's control word or its count word. The control word holds a match period, an interrupt enable, a pending flag and a two-bit run mode. In any mode other than off, the count word advances by one every clock. When the low period bits of the count equal the period, the pending flag is raised. The mode then decides what happens next: the count returns to zero (restart), stops (one-shot) or keeps going (continuous).

A timer interrupt line is asserted while the pending flag and the enable are both set. Software acknowledges the interrupt by writing the control word with the pending bit at 0. Writing that bit as 1 leaves the flag as it is, so software cannot raise the flag itself. Clock prescaling and interrupt routing sit outside this block.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word and the count word read as 0 and `irq` is low.
- R2: The control word is at address 0x5000 (group 10, number 0) and the count word is at 0x5001 (group 10, number 1). A read of any other address returns 0. A write to any other address changes nothing.
- R3: Control word layout: period in bits 27:0, pending in bit 28, enable in bit 29, mode in bits 31:30 (00 off, 01 restart, 10 one-shot, 11 continuous). A read returns the stored fields in these positions.
- R4: In mode off the count word holds its value.
- R5: A match is when the timer is running and count[27:0] equals the period. A match sets pending. In restart mode the count reads 0 on the following cycle.
- R6: In one-shot mode a match sets pending and the count then holds. It stays held until the next write to the control word or the count word.
- R7: In continuous mode a match sets pending and the count keeps incrementing.
- R8: A control-word write with bit 28 = 1 leaves pending at its previous value. The other fields take the written values.
- R9: A control-word write with bit 28 = 0 clears pending, so `irq` drops.
- R10: If a match and a control-word write with bit 28 = 0 fall in the same cycle, pending ends up set.
- R11: A count-word write loads the written value and takes priority over the increment. Counting then resumes from that value unless the mode is off.
- R12: `irq` is high exactly when pending and enable are both set.
- R13: Within a cycle, counting and matching use the register values from before that cycle's write. A count-word read always returns the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spr_we | input | 1 | Write strobe for the register port |
| spr_addr | input | 16 | Register address: group in bits 15:11, number in bits 10:0 |
| spr_wdata | input | 32 | Write data |
| spr_rdata | output | 32 | Read data for `spr_addr`, combinational |
| irq | output | 1 | Timer interrupt request |

## Verification
The assertions assume that `spr_we`, `spr_addr` and `spr_wdata` are stable and known at every rising edge. They also assume that only one register is addressed per cycle. The bench drives all inputs on the falling edge, one access per cycle, and otherwise leaves the count address selected so that the count can be compared every clock. The case of a match and an acknowledge in the same cycle is reached by stepping the reference model until it is about to match. The bench then issues the acknowledge in exactly that cycle.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter logic [AW-1:0] CTRL_ADDR  = 16'h5000,
  parameter logic [AW-1:0] COUNT_ADDR = 16'h5001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spr_we,
  input  logic [AW-1:0] spr_addr,
  input  logic [DW-1:0] spr_wdata,
  output logic [DW-1:0] spr_rdata,
  output logic          irq
);
  localparam int PW   = DW - 4;
  localparam int PEND = PW;
  localparam int ENAB = PW + 1;
  localparam logic [1:0] M_OFF = 2'b00, M_RESTART = 2'b01, M_ONCE = 2'b10;

  logic [PW-1:0] period;
  logic          pend, enab, done;
  logic [1:0]    mode;
  logic [DW-1:0] count;

  wire ctrl_sel = spr_addr == CTRL_ADDR;
  wire cnt_sel  = spr_addr == COUNT_ADDR;
  wire ctrl_wr  = spr_we && ctrl_sel;
  wire cnt_wr   = spr_we && cnt_sel;
  wire running  = (mode != M_OFF) && !done;
  wire hit      = running && (count[PW-1:0] == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period <= '0;
      pend   <= 1'b0;
      enab   <= 1'b0;
      mode   <= M_OFF;
      count  <= '0;
      done   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        period <= spr_wdata[PW-1:0];
        enab   <= spr_wdata[ENAB];
        mode   <= spr_wdata[DW-1:DW-2];
      end
      pend <= hit | (ctrl_wr ? (spr_wdata[PEND] & pend) : pend);
      if (cnt_wr)
        count <= spr_wdata;
      else if (hit && mode == M_RESTART)
        count <= '0;
      else if (running && !(hit && mode == M_ONCE))
        count <= count + 1'b1;
      if (ctrl_wr || cnt_wr)
        done <= 1'b0;
      else if (hit && mode == M_ONCE)
        done <= 1'b1;
    end
  end

  assign spr_rdata = ctrl_sel ? {mode, enab, pend, period} :
                     cnt_sel  ? count : '0;
  assign irq = pend & enab;

  // R4
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF && !cnt_wr) |=> $stable(count));
  // R5
  match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend);
  // R6
  once_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctrl_wr && !cnt_wr) |=> $stable(count));
  // R8
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && spr_wdata[PEND] && !hit) |=> pend == $past(pend));
  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !spr_wdata[PEND] && !hit) |=> !pend && !irq);
  // R11
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(spr_wdata));
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  localparam logic [15:0] CA = 16'h5000, NA = 16'h5001;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [15:0] addr = NA;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int vectors = 0, miscompares = 0;
  bit ended = 0;

  logic [27:0] m_per = '0;
  logic m_pend = 0, m_en = 0, m_done = 0;
  logic [1:0] m_mode = '0;
  logic [31:0] m_cnt = '0;

  always #10 clk = ~clk;

  tick_timer u_tick_timer (.clk(clk), .rst_n(rst_n), .spr_we(we), .spr_addr(addr),
                           .spr_wdata(wdata), .spr_rdata(rdata), .irq(irq));

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit w, input logic [15:0] a, input logic [31:0] d, input string req);
    logic [31:0] exp_rd, n_cnt;
    logic run, hit, cw, nw, n_pend, n_done;
    @(negedge clk);
    we = w; addr = a; wdata = d;
    #1;
    exp_rd = (a == CA) ? {m_mode, m_en, m_pend, m_per} : (a == NA) ? m_cnt : 32'h0;
    cmp(rdata, exp_rd, req);
    cmp({31'h0, irq}, {31'h0, m_pend & m_en}, "R12");
    run = (m_mode != 2'b00) && !m_done;
    hit = run && (m_cnt[27:0] == m_per);
    cw = w && a == CA;
    nw = w && a == NA;
    n_pend = hit || (cw ? (d[28] && m_pend) : m_pend);
    if (nw) n_cnt = d;
    else if (hit && m_mode == 2'b01) n_cnt = 0;
    else if (hit && m_mode == 2'b10) n_cnt = m_cnt;
    else if (run) n_cnt = m_cnt + 1;
    else n_cnt = m_cnt;
    n_done = (cw || nw) ? 1'b0 : (m_done || (hit && m_mode == 2'b10));
    @(posedge clk);
    m_pend = n_pend; m_cnt = n_cnt; m_done = n_done;
    if (cw) begin m_per = d[27:0]; m_en = d[29]; m_mode = d[31:30]; end
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(0, NA, 0, req);
  endtask

  function automatic logic [31:0] ctl(input logic [1:0] md, input bit en, input bit p, input int per);
    return {md, en, p, per[27:0]};
  endfunction

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(0, CA, 0, "R1");
    step(0, NA, 0, "R1");
    step(1, NA, 32'd7, "R11");
    idle(4, "R4");
    step(1, 16'h5002, 32'hFFFF_FFFF, "R2");
    step(0, 16'h5002, 0, "R2");
    step(0, CA, 0, "R2");
    step(1, NA, 32'd0, "R11");
    step(1, CA, ctl(2'b01, 1, 0, 4), "R3");
    step(0, CA, 0, "R3");
    idle(14, "R5");
    step(1, CA, ctl(2'b01, 1, 1, 4), "R8");
    step(0, CA, 0, "R8");
    idle(2, "R8");
    step(1, CA, ctl(2'b01, 1, 0, 4), "R9");
    idle(3, "R9");
    step(1, NA, 32'd0, "R11");
    step(1, CA, ctl(2'b10, 0, 0, 3), "R6");
    idle(10, "R6");
    step(1, NA, 32'd1, "R11");
    idle(6, "R6");
    step(1, CA, ctl(2'b11, 1, 0, 2), "R7");
    step(1, NA, 32'd0, "R7");
    idle(10, "R7");
    step(1, CA, ctl(2'b11, 1, 0, 5), "R10");
    step(1, NA, 32'd0, "R10");
    while (m_cnt[27:0] != 28'd5) step(0, NA, 0, "R13");
    step(1, CA, ctl(2'b11, 1, 0, 5), "R10");
    step(0, CA, 0, "R10");
    idle(3, "R10");
    step(1, CA, ctl(2'b00, 1, 0, 9), "R4");
    idle(5, "R4");
    step(1, NA, 32'h0ABC_0000, "R11");
    idle(3, "R4");
    step(0, 16'h0000, 0, "R2");
    finish_run();
  end
endmodule